// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Digit Converter

This block turns an unsigned binary operand of `WIDTH` bits into packed decimal digits, four bits per digit. It works serially. A start strobe loads the operand. The block then takes one operand bit per clock, most significant bit first, into a decimal accumulator. Before each of these shifts, every four-bit column of the accumulator that holds 5 to 9 has three added to it. Doubling that column then carries into the next column instead of forming one of the codes A to F.

A conversion takes exactly `WIDTH` shift cycles after the start is accepted. At the end, a one-cycle done pulse marks the moment the result register loads. The result then stays unchanged until the next conversion completes. The number of digits is derived from `WIDTH` so that the largest operand always fits. For example, three digits serve an 8-bit operand and five digits serve a 16-bit operand.

Top module: `bin2bcd_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, busy and done are low and the result bus is all zeros.
- R2: A start strobe sampled while busy is low loads the operand, and busy reads high from the following cycle.
- R3: Done is high for exactly one cycle, exactly `WIDTH` clock edges after the edge that accepted the start. Busy falls on the same edge that raises done.
- R4: The result holds the decimal value of the operand. Digit i sits at bits [4i+3:4i], so the units digit is in bits [3:0].
- R5: Every four-bit digit of the result bus is always in the range 0 to 9.
- R6: A start strobe sampled while busy is high is ignored. The running conversion finishes on time with the result of its own operand.
- R7: The result bus keeps its value on every cycle in which done is low.
- R8: The extreme operands convert correctly: 0 gives all-zero digits, and 2^WIDTH-1 fits in the derived digit count.
- R9: A start sampled on the cycle in which done is high is accepted, so conversions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion of `operand` when idle |
| operand | input | WIDTH | Unsigned binary value |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result loads |
| bcd_out | output | 4*DIGITS | Packed decimal digits, units digit at bits [3:0] |

## Verification
The 8-bit sweep covers every operand, so every digit value reaches the correction step at every shift position. A wrong threshold (4 or 6 instead of 5), a missing +3, or a correction applied after the last shift would therefore give wrong digits or codes above 9. Randomly chosen 16-bit operands, together with 0 and 65535, check the derived digit count: if it were too small, the top digit of large values would be lost. Timing is checked by counting cycles from start to done. An off-by-one in the shift counter would move done a cycle early or late and leave one bit unshifted or shifted twice. Starts issued mid-conversion and on the done cycle check that a busy block ignores the strobe and that an idle one accepts it at once.

// File: rtl/bin2bcd_pkg.sv
package bin2bcd_pkg;
  // Decimal digits needed for the largest WIDTH-bit value: floor(WIDTH*log10(2)) + 1
  function automatic int dec_digits(input int bits);
    return (bits * 30103) / 100000 + 1;
  endfunction
endpackage

// File: rtl/bcd_digit_adj.sv
// Pre-shift correction of one decimal column: 5..9 gain three, 0..4 pass,
// codes above 9 cannot occur and are forced to zero.
module bcd_digit_adj (
  input  logic [3:0] d,
  output logic [3:0] q
);
  always_comb begin
    if (d <= 4'd4)      q = d;
    else if (d <= 4'd9) q = d + 4'd3;
    else                q = 4'd0;
  end
endmodule

// File: rtl/bin2bcd_ctrl.sv
module bin2bcd_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic shift_en,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  assign load     = start & ~busy_q;
  assign shift_en = busy_q;
  assign last     = busy_q && (cnt_q == CW'(1));
  assign busy     = busy_q;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        cnt_q  <= CW'(WIDTH);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CW'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bin2bcd_shifter.sv
module bin2bcd_shifter #(
  parameter int WIDTH  = 8,
  parameter int DIGITS = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  shift_en,
  input  logic                  capture,
  input  logic [WIDTH-1:0]      operand,
  output logic [4*DIGITS-1:0]   result
);
  localparam int BCDW = 4 * DIGITS;

  logic [WIDTH-1:0] bin_q;
  logic [BCDW-1:0]  acc_q;
  logic [BCDW-1:0]  acc_adj;
  logic [BCDW-1:0]  acc_nxt;
  logic [BCDW-1:0]  result_q;

  for (genvar g = 0; g < DIGITS; g++) begin : g_col
    bcd_digit_adj u_adj (
      .d (acc_q[4*g +: 4]),
      .q (acc_adj[4*g +: 4])
    );
  end

  // Corrected accumulator doubled with the next operand bit entering at the bottom
  assign acc_nxt = {acc_adj[BCDW-2:0], bin_q[WIDTH-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q    <= '0;
      acc_q    <= '0;
      result_q <= '0;
    end else begin
      if (load) begin
        bin_q <= operand;
        acc_q <= '0;
      end else if (shift_en) begin
        bin_q <= bin_q << 1;
        acc_q <= acc_nxt;
      end
      if (capture) result_q <= acc_nxt;
    end
  end

  assign result = result_q;
endmodule

// File: rtl/bin2bcd_seq.sv
module bin2bcd_seq
  import bin2bcd_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int DIGITS = dec_digits(WIDTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [WIDTH-1:0]    operand,
  output logic                busy,
  output logic                done,
  output logic [4*DIGITS-1:0] bcd_out
);
  logic load;
  logic shift_en;
  logic last;

  bin2bcd_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .load     (load),
    .shift_en (shift_en),
    .last     (last),
    .busy     (busy),
    .done     (done)
  );

  bin2bcd_shifter #(.WIDTH(WIDTH), .DIGITS(DIGITS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .shift_en (shift_en),
    .capture  (last),
    .operand  (operand),
    .result   (bcd_out)
  );
endmodule

// File: rtl/bin2bcd_seq_chk.sv
module bin2bcd_seq_chk #(
  parameter int WIDTH  = 8,
  parameter int DIGITS = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [WIDTH-1:0]    operand,
  input logic                busy,
  input logic                done,
  input logic [4*DIGITS-1:0] bcd_out
);
  int lat_q;

  always_ff @(posedge clk) begin
    if (rst)                lat_q <= 0;
    else if (start && !busy) lat_q <= 0;
    else if (busy)          lat_q <= lat_q + 1;
  end

  a_r2_start_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == WIDTH));

  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(bcd_out));

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    a_r5_digit_legal: assert property (@(posedge clk) disable iff (rst)
      bcd_out[4*g +: 4] <= 4'd9);
  end
endmodule

bind bin2bcd_seq bin2bcd_seq_chk #(.WIDTH(WIDTH), .DIGITS(DIGITS)) u_chk (.*);

// File: tb/bin2bcd_seq_bench.sv
`timescale 1ns/1ps
module bin2bcd_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // 8-bit instance
  logic        start8 = 1'b0;
  logic [7:0]  op8 = '0;
  logic        busy8, done8;
  logic [11:0] out8;

  bin2bcd_seq #(.WIDTH(8)) u_bin2bcd_seq (
    .clk(clk), .rst(rst), .start(start8), .operand(op8),
    .busy(busy8), .done(done8), .bcd_out(out8)
  );

  // 16-bit instance
  logic        start16 = 1'b0;
  logic [15:0] op16 = '0;
  logic        busy16, done16;
  logic [19:0] out16;

  bin2bcd_seq #(.WIDTH(16)) u_bin2bcd_seq_w16 (
    .clk(clk), .rst(rst), .start(start16), .operand(op16),
    .busy(busy16), .done(done16), .bcd_out(out16)
  );

  function automatic logic [63:0] ref_bcd(input longint unsigned v);
    logic [63:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Wait for done8 from the negedge after the accepting edge; returns edge count
  task automatic wait_done8(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done8 && cyc < 40);
  endtask

  task automatic wait_done16(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done16 && cyc < 60);
  endtask

  // Full 8-bit conversion, with an optional stray start mid-run (R6)
  task automatic conv8(input logic [7:0] v, input bit stray);
    int cyc;
    logic [11:0] held;
    @(negedge clk);
    start8 = 1'b1; op8 = v;
    @(negedge clk);
    start8 = 1'b0; op8 = ~v;
    check("R2 busy after start", busy8, 1);
    if (stray) begin
      @(negedge clk);
      start8 = 1'b1;
      @(negedge clk);
      start8 = 1'b0;
      wait_done8(cyc);
      cyc += 2;
      check("R6 stray start latency", cyc, 8);
    end else begin
      wait_done8(cyc);
      check("R3 latency", cyc, 8);
    end
    check("R3 busy low at done", busy8, 0);
    check("R4 result", out8, ref_bcd(64'(v)) & 64'hFFF);
    held = out8;
    @(negedge clk);
    check("R3 done one cycle", done8, 0);
    check("R7 result held", out8, held);
  endtask

  task automatic conv16(input logic [15:0] v);
    int cyc;
    @(negedge clk);
    start16 = 1'b1; op16 = v;
    @(negedge clk);
    start16 = 1'b0;
    check("R2 busy after start w16", busy16, 1);
    wait_done16(cyc);
    check("R3 latency w16", cyc, 16);
    check("R4 result w16", out16, ref_bcd(64'(v)) & 64'hFFFFF);
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy8, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", busy8, 0);
    check("R1 done after reset", done8, 0);
    check("R1 result after reset", out8, 0);
    check("R1 result after reset w16", out16, 0);

    // R4 R5: exhaustive 8-bit sweep
    for (int v = 0; v < 256; v++) conv8(8'(v), 1'b0);

    // R8: extremes
    conv8(8'd0, 1'b0);
    conv8(8'd255, 1'b0);
    conv16(16'd0);
    conv16(16'hFFFF);
    check("R8 top digit of 65535", out16[19:16], 6);

    // R6: stray start while busy must not disturb the run
    conv8(8'd59, 1'b1);
    conv8(8'd199, 1'b1);

    // R9: back-to-back, start on the done cycle
    @(negedge clk);
    start8 = 1'b1; op8 = 8'd97;
    @(negedge clk);
    start8 = 1'b0;
    wait_done8(cyc);
    start8 = 1'b1; op8 = 8'd250;
    @(negedge clk);
    start8 = 1'b0;
    check("R9 accepted on done cycle", busy8, 1);
    wait_done8(cyc);
    check("R9 latency", cyc, 8);
    check("R9 result", out8, 12'h250);

    // R4: random 16-bit operands
    for (int k = 0; k < 300; k++) conv16(16'($urandom));

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
      $finish;
    end
  end
endmodule